// File: doc/BRIEF.md
# Four-bit arithmetic logic unit with operand shaper

This block combines two four-bit operands in one of twelve ways. The mode bit chooses between an arithmetic path and a logic path. In the arithmetic path, a per-bit operand shaper first builds a modified operand Y from B and the two select bits, Y_i = (B_i & S0) | (~B_i & S1). Four full adders then ripple the sum A + Y + carry_in from the least significant bit to the most significant bit. The arithmetic operations are not decoded from an opcode. All eight of them come from Y and the carry-in: pass-through, increment, add, add with carry, add of the complement, subtract and decrement.

The logic path applies one of four bitwise functions, selected by the same two select bits. A final multiplexer driven by the mode bit picks the path. When the parameter `REG_OUT` is 1 (the default), the result and carry-out are captured in an output register on the rising clock edge. An active-low reset clears that register asynchronously. When `REG_OUT` is 0, the outputs are purely combinational.

Top module: `nib_alu`

## Requirements
- R1: `mode_logic`=0 sends the arithmetic result to `result`, and `mode_logic`=1 sends the logic result.
- R2: The arithmetic result is the low four bits of A + Y + `carry_in`, where Y_i = (B_i & sel[0]) | (~B_i & sel[1]). `carry_out` is the carry out of bit 3.
- R3: With {sel[1],sel[0],carry_in} as the code, the arithmetic operations are: 000 gives A, 001 gives A+1, 010 gives A+B, 011 gives A+B+1, 100 gives A+~B, 101 gives A+~B+1, 110 gives A-1, and 111 gives A.
- R4: With sel=11, Y is 1111. With carry_in=0 the result is A-1, and carry_out is 1 unless A=0. With carry_in=1 the result is A and carry_out is 1.
- R5: In logic mode, sel selects the function: 00 gives A XOR B, 01 gives A OR B, 10 gives A AND B, and 11 gives NOT A. carry_in has no effect on `result`.
- R6: In logic mode, `carry_out` is 0.
- R7: With A=1111, B=0000 and sel=01, carry_in=0 gives result 1111 and carry_out 0. carry_in=1 gives result 0000 and carry_out 1, with the carry rippling through all four stages.
- R8: With A=0111 and sel=01, B=1000 gives result 1111 and carry_out 0. Changing only B0 to 1 gives result 0000 and carry_out 1.
- R9: With REG_OUT=1, the outputs show the operation on the inputs present at the previous rising edge of `clk`. While `rst_n` is low, `result` and `carry_out` are 0, and they clear as soon as `rst_n` falls, without waiting for a clock edge.
- R10: The code 101 computes A-B. carry_out is 1 exactly when A >= B as unsigned numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| opnd_a | input | 4 | Operand A |
| opnd_b | input | 4 | Operand B |
| mode_logic | input | 1 | 0 selects the arithmetic path, 1 selects the logic path |
| sel | input | 2 | Function select; sel[1] is S1 and sel[0] is S0 |
| carry_in | input | 1 | Carry into bit 0 |
| result | output | 4 | Result F |
| carry_out | output | 1 | Carry out of bit 3; 0 in logic mode |

## Verification
With the default registered output, each result and carry-out is due one rising edge after its inputs are applied. The bench drives inputs on a falling edge and compares on the next falling edge, half a period after the capturing edge. The reset check is different because the clear is asynchronous. The bench drops `rst_n` between edges and samples the outputs a fraction of a nanosecond later, without waiting for a clock. The first result after reset is released is expected on the first rising edge that follows the release.

// File: rtl/nib_alu_pkg.sv
package nib_alu_pkg;
  // Bitwise function chosen by sel in logic mode
  typedef enum logic [1:0] {
    LOP_XOR  = 2'b00,
    LOP_OR   = 2'b01,
    LOP_AND  = 2'b10,
    LOP_NOTA = 2'b11
  } lop_e;
endpackage

// File: rtl/nib_opgen.sv
module nib_opgen #(
  parameter int W = 4
) (
  input  logic [W-1:0] b_in,
  input  logic         s0,
  input  logic         s1,
  output logic [W-1:0] y_out
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign y_out[i] = (b_in[i] & s0) | (~b_in[i] & s1);
  end
endmodule

// File: rtl/nib_fa.sv
module nib_fa (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (x & ci) | (y & ci);
endmodule

// File: rtl/nib_ripple.sv
module nib_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] sum,
  output logic         co
);
  logic [W:0] cy;
  assign cy[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_stage
    nib_fa u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (cy[i]),
      .s  (sum[i]),
      .co (cy[i+1])
    );
  end

  assign co = cy[W];
endmodule

// File: rtl/nib_logic.sv
module nib_logic
  import nib_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  lop_e         op,
  output logic [W-1:0] f
);
  always_comb begin
    unique case (op)
      LOP_XOR:  f = a ^ b;
      LOP_OR:   f = a | b;
      LOP_AND:  f = a & b;
      default:  f = ~a;
    endcase
  end
endmodule

// File: rtl/nib_alu.sv
module nib_alu
  import nib_alu_pkg::*;
#(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         mode_logic,
  input  logic [1:0]   sel,
  input  logic         carry_in,
  output logic [W-1:0] result,
  output logic         carry_out
);
  logic [W-1:0] y_op;
  logic [W-1:0] arith_f;
  logic         arith_c;
  logic [W-1:0] logic_f;
  logic [W-1:0] res_d;
  logic         cout_d;

  nib_opgen #(.W(W)) u_opgen (
    .b_in  (opnd_b),
    .s0    (sel[0]),
    .s1    (sel[1]),
    .y_out (y_op)
  );

  nib_ripple #(.W(W)) u_ripple (
    .x   (opnd_a),
    .y   (y_op),
    .ci  (carry_in),
    .sum (arith_f),
    .co  (arith_c)
  );

  nib_logic #(.W(W)) u_logic (
    .a  (opnd_a),
    .b  (opnd_b),
    .op (lop_e'(sel)),
    .f  (logic_f)
  );

  // Next-state: final path selection
  always_comb begin
    if (mode_logic) begin
      res_d  = logic_f;
      cout_d = 1'b0;
    end else begin
      res_d  = arith_f;
      cout_d = arith_c;
    end
  end

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        result    <= '0;
        carry_out <= 1'b0;
      end else begin
        result    <= res_d;
        carry_out <= cout_d;
      end
    end
  end else begin : g_comb
    assign result    = res_d;
    assign carry_out = cout_d;
  end
endmodule

// File: rtl/nib_alu_chk.sv
module nib_alu_chk #(
  parameter int W       = 4,
  parameter bit REG_OUT = 1'b1
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] opnd_a,
  input logic [W-1:0] opnd_b,
  input logic         mode_logic,
  input logic [1:0]   sel,
  input logic         carry_in,
  input logic [W-1:0] result,
  input logic         carry_out
);
  if (REG_OUT) begin : g_chk
    // R9: reset holds the outputs at zero
    p_reset_clear_r9: assert property (@(posedge clk)
      !rst_n |-> (result == '0 && carry_out == 1'b0));

    // R6: no carry-out after a logic-mode cycle
    p_logic_nocarry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && mode_logic) |-> carry_out == 1'b0);

    // R5: complement function
    p_nota_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && mode_logic && sel == 2'b11) |-> result == ~$past(opnd_a));

    // R3: pass-through code 000
    p_transfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !mode_logic && sel == 2'b00 && !carry_in)
      |-> (result == $past(opnd_a) && carry_out == 1'b0));

    // R4: code 111 returns A with carry set
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !mode_logic && sel == 2'b11 && carry_in)
      |-> (result == $past(opnd_a) && carry_out == 1'b1));

    // R2: plain addition carries into carry_out
    p_add_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && !mode_logic && sel == 2'b01 && !carry_in)
      |-> {carry_out, result} == ({1'b0, $past(opnd_a)} + {1'b0, $past(opnd_b)}));
  end
endmodule

bind nib_alu nib_alu_chk #(.W(W), .REG_OUT(REG_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .mode_logic (mode_logic),
  .sel        (sel),
  .carry_in   (carry_in),
  .result     (result),
  .carry_out  (carry_out)
);

// File: tb/sim_nib_alu.sv
`timescale 1ns/1ps
module sim_nib_alu;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] a, b;
  logic       m;
  logic [1:0] s;
  logic       ci;
  logic [3:0] f;
  logic       co;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  nib_alu u0 (
    .clk(clk), .rst_n(rst_n), .opnd_a(a), .opnd_b(b), .mode_logic(m),
    .sel(s), .carry_in(ci), .result(f), .carry_out(co)
  );

  // Row layout: {req[20:17], a[16:13], b[12:9], m[8], s[7:6], ci[5], f[4:1], co[0]}
  localparam int NV = 18;
  localparam logic [20:0] VEC [NV] = '{
    {4'd3,  4'b1010, 4'b0101, 1'b0, 2'b00, 1'b0, 4'b1010, 1'b0}, // R3 transfer
    {4'd3,  4'b1010, 4'b0101, 1'b0, 2'b00, 1'b1, 4'b1011, 1'b0}, // R3 increment
    {4'd3,  4'b0011, 4'b0101, 1'b0, 2'b01, 1'b0, 4'b1000, 1'b0}, // R3 add
    {4'd3,  4'b1001, 4'b1000, 1'b0, 2'b01, 1'b1, 4'b0010, 1'b1}, // R3 add+1
    {4'd3,  4'b0110, 4'b0010, 1'b0, 2'b10, 1'b0, 4'b0011, 1'b1}, // R3 A+~B
    {4'd10, 4'b0110, 4'b0010, 1'b0, 2'b10, 1'b1, 4'b0100, 1'b1}, // R10 A>B
    {4'd10, 4'b0010, 4'b0110, 1'b0, 2'b10, 1'b1, 4'b1100, 1'b0}, // R10 A<B
    {4'd4,  4'b0000, 4'b1010, 1'b0, 2'b11, 1'b0, 4'b1111, 1'b0}, // R4 decrement of zero
    {4'd4,  4'b0101, 4'b0000, 1'b0, 2'b11, 1'b0, 4'b0100, 1'b1}, // R4 decrement
    {4'd4,  4'b0111, 4'b0011, 1'b0, 2'b11, 1'b1, 4'b0111, 1'b1}, // R4 transfer, carry set
    {4'd7,  4'b1111, 4'b0000, 1'b0, 2'b01, 1'b0, 4'b1111, 1'b0}, // R7 no ripple
    {4'd7,  4'b1111, 4'b0000, 1'b0, 2'b01, 1'b1, 4'b0000, 1'b1}, // R7 full ripple
    {4'd8,  4'b0111, 4'b1000, 1'b0, 2'b01, 1'b0, 4'b1111, 1'b0}, // R8 B0 low
    {4'd8,  4'b0111, 4'b1001, 1'b0, 2'b01, 1'b0, 4'b0000, 1'b1}, // R8 B0 high
    {4'd5,  4'b1100, 4'b1010, 1'b1, 2'b00, 1'b1, 4'b0110, 1'b0}, // R5 xor, R6
    {4'd5,  4'b1100, 4'b1010, 1'b1, 2'b01, 1'b1, 4'b1110, 1'b0}, // R5 or
    {4'd5,  4'b1100, 4'b1010, 1'b1, 2'b10, 1'b0, 4'b1000, 1'b0}, // R5 and
    {4'd1,  4'b1100, 4'b1010, 1'b1, 2'b11, 1'b1, 4'b0011, 1'b0}  // R1 logic path, NOT A
  };

  // Reference from the encoding tables (R3, R5, R6), returns {co, f}
  function automatic logic [4:0] model(input logic [3:0] xa, input logic [3:0] xb,
                                       input logic xm, input logic [1:0] xs, input logic xc);
    logic [4:0] ea, eb;
    ea = {1'b0, xa};
    eb = {1'b0, xb};
    if (xm) begin
      case (xs)
        2'b00:   return {1'b0, xa ^ xb};
        2'b01:   return {1'b0, xa | xb};
        2'b10:   return {1'b0, xa & xb};
        default: return {1'b0, ~xa};
      endcase
    end
    case ({xs, xc})
      3'b000:  return ea;
      3'b001:  return ea + 5'd1;
      3'b010:  return ea + eb;
      3'b011:  return ea + eb + 5'd1;
      3'b100:  return ea + {1'b0, ~xb};
      3'b101:  return ea + {1'b0, ~xb} + 5'd1;
      3'b110:  return ea + 5'd15;
      default: return ea + 5'd16;
    endcase
  endfunction

  task automatic check(input int req, input logic [3:0] f_exp, input logic c_exp);
    tests++;
    if (f !== f_exp || co !== c_exp) begin
      fails++;
      $display("FAIL R%0d: got f=%b co=%b, expected f=%b co=%b", req, f, co, f_exp, c_exp);
    end
  endtask

  task automatic drive(input logic [3:0] xa, input logic [3:0] xb, input logic xm,
                       input logic [1:0] xs, input logic xc);
    @(negedge clk);
    a = xa; b = xb; m = xm; s = xs; ci = xc;
    @(negedge clk); // one capture edge has passed
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    a = 4'hF; b = 4'hF; m = 1'b0; s = 2'b01; ci = 1'b1;
    repeat (3) @(negedge clk);
    check(9, 4'b0000, 1'b0); // R9 reset state
    rst_n = 1'b1;

    // Directed table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][16:13], VEC[i][12:9], VEC[i][8], VEC[i][7:6], VEC[i][5]);
      check(int'(VEC[i][20:17]), VEC[i][4:1], VEC[i][0]);
    end

    // Exhaustive sweep: R1, R2, R3, R5, R6 against the table model
    for (int v = 0; v < 8192; v++) begin
      logic [4:0] exp_v;
      logic [12:0] vv;
      vv = 13'(v);
      drive(vv[12:9], vv[8:5], vv[4], vv[3:2], vv[1]);
      exp_v = model(vv[12:9], vv[8:5], vv[4], vv[3:2], vv[1]);
      check(vv[4] ? 5 : 2, exp_v[3:0], exp_v[4]);
    end

    // R9: asynchronous clear between edges, then recovery on the first edge
    drive(4'b1111, 4'b0000, 1'b0, 2'b01, 1'b1);
    check(7, 4'b0000, 1'b1);
    drive(4'b0110, 4'b0011, 1'b0, 2'b01, 1'b1);
    check(9, 4'b1010, 1'b0);
    #0.5 rst_n = 1'b0;
    #0.3 check(9, 4'b0000, 1'b0);
    @(negedge clk);
    check(9, 4'b0000, 1'b0); // held through an edge
    rst_n = 1'b1;
    @(negedge clk);
    check(9, 4'b1010, 1'b0); // first edge after release

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule